// File: doc/BRIEF.md
# Proximity Threshold Interrupt Controller

This block sits between a proximity converter that delivers 8-bit samples and the host-facing register logic. Each new sample arrives with a one-cycle strobe. The block turns the sample stream into one active-low interrupt pin. A 3-bit mode field selects what the pin means. In comparator mode it acts as a proximity switch with hysteresis set by a high and a low threshold. In wake-up mode it raises a latched flag when the high threshold is crossed. In data-ready mode it signals that a new sample is waiting to be read.

The block also holds the data register that the host reads. That register loads the most recent sample only when a read of it begins, so a slow host always sees one coherent value. If a sample arrives while such a read is still in progress, the data-ready pin gives a short fixed-length pulse instead of a level. The block builds a status byte from the oscillator-stopped flag, the data-fresh flag, the wake-up latch and the comparator state.

The block has no serial framing of its own. The read strobes, the thresholds and the mode field come from the surrounding register interface.

Top module: `prox_irq_ctrl`

## Requirements
- R1: The mode field decodes as 3'b001 wake-up, 3'b010 comparator and 3'b100 data-ready. Code 3'b000 and every other code mean off. While the registered mode is off, `irq_n_o` is high.
- R2: The comparator state is set by a strobed sample strictly greater than `thr_hi_i`, and cleared by one strictly less than `thr_lo_i`. A sample equal to a threshold, or between the two thresholds, leaves the state unchanged. In comparator mode, `irq_n_o` is low exactly while the state is set, two clock edges after the strobe.
- R3: In wake-up mode, a strobed sample strictly greater than `thr_hi_i` latches the wake flag and drives `irq_n_o` low. Later low samples do not release the flag. Only a change of the mode field releases it.
- R4: A strobed sample that arrives with no read in progress sets the fresh flag. A read start clears it. If a sample and a read start fall in the same cycle, the flag ends up set. In data-ready mode, `irq_n_o` is low while the flag is set.
- R5: A read is in progress from the cycle after `rd_start_i` until `rd_end_i`. A strobed sample during a read does not set the fresh flag. Instead it drives `irq_n_o` low for exactly PULSE_CYC cycles in data-ready mode.
- R6: `data_o` loads the latest strobed sample taken before the current cycle, on a cycle with `rd_start_i` high. It is unchanged on every other cycle.
- R7: The status byte is laid out as follows: bit 7 = `osc_stop_i`; bit 6 = 0 when fresh data is waiting; bit 5 = 0 when the wake flag is latched; bit 4 = 1 when the comparator state is clear (below low) and 0 when it is set (above high); bits 3:0 = 0.
- R8: After reset, `irq_n_o` = 1, `data_o` = 0 and `status_o` = 8'h70 (with `osc_stop_i` low).
- R9: A change of the mode field clears the comparator state, the wake flag and any running pulse. A strobed sample in the same cycle as the change does not set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | DW | Proximity sample value |
| sample_vld_i | input | 1 | One-cycle strobe marking a new sample |
| thr_hi_i | input | DW | High threshold |
| thr_lo_i | input | DW | Low threshold |
| mode_i | input | 3 | Interrupt pin mode field |
| rd_start_i | input | 1 | Strobe marking the start of a data register read |
| rd_end_i | input | 1 | Strobe marking the end of that read |
| osc_stop_i | input | 1 | Oscillator-stopped flag |
| irq_n_o | output | 1 | Active-low interrupt pin (registered) |
| data_o | output | DW | Data register |
| status_o | output | 8 | Status byte |

## Verification
Each flag in this block feeds both the interrupt pin and a status bit. A wrong comparator, wake or fresh flag therefore shows on `status_o` one edge after the input that caused it, and on `irq_n_o` one edge later. A wrong read-in-progress state shows only when a later sample arrives: the pin then gives a pulse where a level was expected, or the reverse. The pulse length shows up as a run of low cycles of the wrong length. A wrong capture in the data register stays visible on `data_o` until the next read start, so it is seen from the cycle after the read start.

// File: rtl/prox_pkg.sv
package prox_pkg;

  localparam int MODE_W = 3;
  localparam int STAT_W = 8;

  typedef enum logic [MODE_W-1:0] {
    PM_OFF  = 3'b000,
    PM_WAKE = 3'b001,
    PM_CMP  = 3'b010,
    PM_DRDY = 3'b100
  } pmode_e;

  // Reserved codes fold to off.
  function automatic pmode_e mode_decode(input logic [MODE_W-1:0] raw);
    case (raw)
      3'b001:  return PM_WAKE;
      3'b010:  return PM_CMP;
      3'b100:  return PM_DRDY;
      default: return PM_OFF;
    endcase
  endfunction

  // Hysteresis step: strict compares, above-high wins if thresholds cross.
  function automatic logic hyst_next(input logic cur, input logic [7:0] smp,
                                     input logic [7:0] hi, input logic [7:0] lo);
    if (smp > hi)      return 1'b1;
    else if (smp < lo) return 1'b0;
    else               return cur;
  endfunction

  // Active-high interrupt request for a decoded mode.
  function automatic logic irq_req(input pmode_e m, input logic cmp,
                                   input logic wk, input logic fresh,
                                   input logic pulse);
    case (m)
      PM_CMP:  return cmp;
      PM_WAKE: return wk;
      PM_DRDY: return fresh | pulse;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] status_pack(input logic osc, input logic fresh,
                                                    input logic wk, input logic cmp);
    return {osc, ~fresh, ~wk, ~cmp, 4'b0000};
  endfunction

endpackage

// File: rtl/prox_hyst.sv
module prox_hyst #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wake_arm_i,
  input  logic          vld_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  output logic          cmp_o,
  output logic          wk_o
);
  import prox_pkg::*;

  logic above_hi;
  assign above_hi = smp_i > hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_o <= 1'b0;
      wk_o  <= 1'b0;
    end else if (clr_i) begin
      cmp_o <= 1'b0;
      wk_o  <= 1'b0;
    end else begin
      if (vld_i) cmp_o <= hyst_next(cmp_o, 8'(smp_i), 8'(hi_i), 8'(lo_i));
      if (vld_i && wake_arm_i && above_hi) wk_o <= 1'b1;
    end
  end

endmodule

// File: rtl/prox_drdy.sv
module prox_drdy #(
  parameter int DW        = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [DW-1:0] smp_i,
  input  logic          rd_start_i,
  input  logic          rd_end_i,
  output logic          fresh_o,
  output logic          busy_o,
  output logic          pulse_o,
  output logic          late_evt_o,
  output logic [DW-1:0] conv_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] PLOAD = CW'(PULSE_CYC);

  logic [CW-1:0] pcnt_q;

  assign late_evt_o = vld_i && busy_o && !clr_i;
  assign pulse_o    = pcnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_o <= 1'b0;
      busy_o  <= 1'b0;
      pcnt_q  <= '0;
      conv_o  <= '0;
      data_o  <= '0;
    end else begin
      if (vld_i) conv_o <= smp_i;
      if (rd_start_i) data_o <= conv_o;

      if (vld_i && !busy_o)  fresh_o <= 1'b1;
      else if (rd_start_i)   fresh_o <= 1'b0;

      if (rd_start_i)        busy_o <= 1'b1;
      else if (rd_end_i)     busy_o <= 1'b0;

      if (clr_i)             pcnt_q <= '0;
      else if (late_evt_o)   pcnt_q <= PLOAD;
      else if (pulse_o)      pcnt_q <= pcnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/prox_irq_ctrl.sv
module prox_irq_ctrl #(
  parameter int DW        = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sample_i,
  input  logic          sample_vld_i,
  input  logic [DW-1:0] thr_hi_i,
  input  logic [DW-1:0] thr_lo_i,
  input  logic [2:0]    mode_i,
  input  logic          rd_start_i,
  input  logic          rd_end_i,
  input  logic          osc_stop_i,
  output logic          irq_n_o,
  output logic [DW-1:0] data_o,
  output logic [7:0]    status_o
);
  import prox_pkg::*;

  logic [MODE_W-1:0] mode_q;
  logic              mode_chg;
  pmode_e            mode_cur;
  logic              cmp_q, wk_q, fresh_q, busy_q, pulse_on, late_evt;
  logic [DW-1:0]     conv_q;

  assign mode_chg = mode_i != mode_q;
  assign mode_cur = mode_decode(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_i;
  end

  prox_hyst #(.DW(DW)) u_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (mode_chg),
    .wake_arm_i (mode_cur == PM_WAKE),
    .vld_i      (sample_vld_i),
    .smp_i      (sample_i),
    .hi_i       (thr_hi_i),
    .lo_i       (thr_lo_i),
    .cmp_o      (cmp_q),
    .wk_o       (wk_q)
  );

  prox_drdy #(.DW(DW), .PULSE_CYC(PULSE_CYC)) u_drdy (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (mode_chg),
    .vld_i      (sample_vld_i),
    .smp_i      (sample_i),
    .rd_start_i (rd_start_i),
    .rd_end_i   (rd_end_i),
    .fresh_o    (fresh_q),
    .busy_o     (busy_q),
    .pulse_o    (pulse_on),
    .late_evt_o (late_evt),
    .conv_o     (conv_q),
    .data_o     (data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= ~irq_req(mode_cur, cmp_q, wk_q, fresh_q, pulse_on);
  end

  assign status_o = status_pack(osc_stop_i, fresh_q, wk_q, cmp_q);

endmodule

// File: rtl/prox_irq_chk.sv
module prox_irq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_q,
  input logic          mode_chg,
  input logic          cmp_q,
  input logic          wk_q,
  input logic          fresh_q,
  input logic          pulse_on,
  input logic          late_evt,
  input logic          sample_vld_i,
  input logic [DW-1:0] sample_i,
  input logic [DW-1:0] thr_hi_i,
  input logic          rd_start_i,
  input logic [DW-1:0] conv_q,
  input logic [DW-1:0] data_o,
  input logic          irq_n_o
);
  logic mode_live;
  assign mode_live = (mode_q == 3'b001) || (mode_q == 3'b010) || (mode_q == 3'b100);

  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_live |=> irq_n_o);

  // R2
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && (sample_i > thr_hi_i) && !mode_chg) |=> cmp_q);

  // R3
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b001 && wk_q && !mode_chg) |=> (wk_q && !irq_n_o));

  // R4
  drdy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b100 && fresh_q) |=> !irq_n_o);

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_evt |=> pulse_on);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start_i |=> $stable(data_o));

  // R6
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_i |=> data_o == $past(conv_q));

  // R9
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!cmp_q && !wk_q && !pulse_on));

endmodule

bind prox_irq_ctrl prox_irq_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_q       (mode_q),
  .mode_chg     (mode_chg),
  .cmp_q        (cmp_q),
  .wk_q         (wk_q),
  .fresh_q      (fresh_q),
  .pulse_on     (pulse_on),
  .late_evt     (late_evt),
  .sample_vld_i (sample_vld_i),
  .sample_i     (sample_i),
  .thr_hi_i     (thr_hi_i),
  .rd_start_i   (rd_start_i),
  .conv_q       (conv_q),
  .data_o       (data_o),
  .irq_n_o      (irq_n_o)
);

// File: tb/sim_prox_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prox_irq_ctrl;
  localparam int DW = 8;
  localparam int PC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] sample = '0, thr_hi = 8'hFF, thr_lo = 8'h00;
  logic vld = 1'b0, rd_s = 1'b0, rd_e = 1'b0, osc = 1'b0;
  logic [2:0] mode = 3'b000;
  logic irq_n;
  logic [DW-1:0] data;
  logic [7:0] status;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prox_irq_ctrl #(.DW(DW), .PULSE_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .thr_hi_i(thr_hi), .thr_lo_i(thr_lo), .mode_i(mode),
    .rd_start_i(rd_s), .rd_end_i(rd_e), .osc_stop_i(osc),
    .irq_n_o(irq_n), .data_o(data), .status_o(status));

  // ---------------- reference model, written from the requirements
  logic [2:0] m_mode;
  logic m_cmp, m_wk, m_fresh, m_busy, m_irqn;
  int m_pc;
  logic [DW-1:0] m_last, m_data;

  function automatic int kind(input logic [2:0] c);
    if (c == 3'b001) return 1;
    if (c == 3'b010) return 2;
    if (c == 3'b100) return 3;
    return 0;
  endfunction

  function automatic logic want_low(input logic [2:0] c, input logic cm, input logic w,
                                    input logic f, input int p);
    int k;
    k = kind(c);
    return (k == 2 && cm) || (k == 1 && w) || (k == 3 && (f || p > 0));
  endfunction

  function automatic logic [7:0] want_status(input logic o, input logic f,
                                             input logic w, input logic cm);
    logic [7:0] s;
    s = 8'h00;
    s[7] = o; s[6] = !f; s[5] = !w; s[4] = !cm;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 3'b000; m_cmp <= 0; m_wk <= 0; m_fresh <= 0; m_busy <= 0;
      m_pc <= 0; m_last <= '0; m_data <= '0; m_irqn <= 1;
    end else begin
      m_irqn <= !want_low(m_mode, m_cmp, m_wk, m_fresh, m_pc);
      m_mode <= mode;
      if (vld) m_last <= sample;
      if (rd_s) m_data <= m_last;
      if (vld && !m_busy) m_fresh <= 1; else if (rd_s) m_fresh <= 0;
      if (rd_s) m_busy <= 1; else if (rd_e) m_busy <= 0;
      if (mode != m_mode) begin
        m_cmp <= 0; m_wk <= 0; m_pc <= 0;
      end else begin
        if (vld && sample > thr_hi) m_cmp <= 1;
        else if (vld && sample < thr_lo) m_cmp <= 0;
        if (vld && sample > thr_hi && kind(m_mode) == 1) m_wk <= 1;
        if (vld && m_busy) m_pc <= PC;
        else if (m_pc > 0) m_pc <= m_pc - 1;
      end
    end
  end

  function automatic string irq_tag(input logic [2:0] c);
    case (kind(c))
      1: return "R3";
      2: return "R2";
      3: return "R4";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (irq_n !== m_irqn) begin
        fails++;
        $display("FAIL %s model irq_n actual=%0b expected=%0b t=%0t", irq_tag(m_mode), irq_n, m_irqn, $time);
      end
      checks++;
      if (data !== m_data) begin
        fails++;
        $display("FAIL R6 model data actual=%h expected=%h t=%0t", data, m_data, $time);
      end
      checks++;
      if (status !== want_status(osc, m_fresh, m_wk, m_cmp)) begin
        fails++;
        $display("FAIL R7 model status actual=%h expected=%h t=%0t", status,
                 want_status(osc, m_fresh, m_wk, m_cmp), $time);
      end
    end
  end

  // ---------------- directed helpers
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [DW-1:0] v);
    sample = v; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] c);
    mode = c;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_begin();
    rd_s = 1'b1; @(negedge clk); rd_s = 1'b0;
  endtask

  task automatic rd_finish();
    rd_e = 1'b1; @(negedge clk); rd_e = 1'b0;
  endtask

  // ---------------- watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 irq_n", irq_n, 1);
    chk("R8 data", data, 0);
    chk("R8 status", status, 8'h70);

    // R2 comparator with strict compares
    thr_hi = 8'd100; thr_lo = 8'd50;
    set_mode(3'b010);
    send(8'd100); @(negedge clk);
    chk("R2 equal high no set", irq_n, 1);
    send(8'd101); @(negedge clk);
    chk("R2 above high asserts", irq_n, 0);
    chk("R7 bit4 above high", status[4], 0);
    send(8'd50); @(negedge clk);
    chk("R2 equal low holds", irq_n, 0);
    send(8'd70); @(negedge clk);
    chk("R2 between holds", irq_n, 0);
    send(8'd49); @(negedge clk);
    chk("R2 below low releases", irq_n, 1);
    chk("R7 bit4 below low", status[4], 1);

    // R1 reserved code is off; R9 change clears comparator
    send(8'd200); @(negedge clk);
    chk("R2 reassert", irq_n, 0);
    set_mode(3'b011);
    chk("R1 reserved code idle", irq_n, 1);
    chk("R9 comparator cleared", status[4], 1);
    send(8'd210); @(negedge clk);
    chk("R1 reserved ignores sample", irq_n, 1);

    // R3 wake-up latch
    set_mode(3'b001);
    send(8'd150);
    chk("R7 bit5 wake latched", status[5], 0);
    @(negedge clk);
    chk("R3 wake asserts", irq_n, 0);
    send(8'd10); @(negedge clk);
    chk("R3 low sample keeps latch", irq_n, 0);
    set_mode(3'b000);
    chk("R1 off idle", irq_n, 1);
    set_mode(3'b001);
    chk("R9 wake released", irq_n, 1);
    chk("R9 wake status", status[5], 1);

    // R4 / R6 data-ready and read capture
    set_mode(3'b100);
    rd_begin(); rd_finish(); @(negedge clk);
    send(8'd33);
    chk("R7 bit6 fresh", status[6], 0);
    @(negedge clk);
    chk("R4 drdy asserts", irq_n, 0);
    rd_begin();
    chk("R6 capture on read", data, 8'd33);
    @(negedge clk);
    chk("R4 read releases", irq_n, 1);
    rd_finish();
    send(8'd44); send(8'd55); @(negedge clk);
    chk("R6 holds without read", data, 8'd33);
    chk("R4 second fresh", irq_n, 0);
    rd_begin(); rd_finish();
    chk("R6 latest captured", data, 8'd55);

    // R5 pulse during a read in progress
    rd_begin();
    @(negedge clk);
    send(8'd77);
    lows = 0;
    for (int i = 0; i < PC + 3; i++) begin
      if (!irq_n) lows++;
      @(negedge clk);
    end
    chk("R5 pulse length", lows, PC);
    chk("R5 fresh not set", status[6], 1);
    rd_finish();

    // R7 oscillator flag
    osc = 1'b1; #1;
    chk("R7 bit7 osc", status[7], 1);
    chk("R7 low nibble", status[3:0], 0);
    @(negedge clk);
    osc = 1'b0;

    // constrained random phase, checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      vld    = ($urandom % 3) == 0;
      sample = 8'($urandom);
      rd_s   = ($urandom % 12) == 0;
      rd_e   = !rd_s && (($urandom % 6) == 0);
      osc    = ($urandom % 50) == 0;
      if (($urandom % 40) == 0) begin
        case ($urandom % 6)
          0: mode = 3'b000; 1: mode = 3'b001; 2: mode = 3'b010;
          3: mode = 3'b100; 4: mode = 3'b011; default: mode = 3'b111;
        endcase
      end
      if (($urandom % 200) == 0) begin
        thr_hi = 8'($urandom); thr_lo = 8'($urandom);
      end
      @(negedge clk);
    end
    vld = 0; rd_s = 0; rd_e = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule